// File: doc/BRIEF.md
# Decrement-and-Skip Instruction Executor

This block runs the two decrement-with-conditional-skip instructions of a small 8-bit controller core. It decodes a 16-bit instruction word and reads one byte from a banked register file. It subtracts one from that byte and writes the result to the working register or back to the file location. It then decides whether the instruction that has already been fetched must be thrown away. The two opcodes share the whole datapath and differ only in the polarity of the skip test.

Each instruction cycle is four clocks long. The phases are decode, operand read, compute and write. A free-running phase counter drives them and is visible at the `phase` output. A new instruction is taken only in the decode phase. When a skip is taken, the block raises a one-clock flush pulse. It then inserts one no-op instruction cycle, or two when the discarded instruction is a two-word one, and holds `busy` high for that time. The program counter moves on by two bytes for every executed or no-op instruction cycle.

The register file has `2**BANK_W` banks of 256 bytes. A side port preloads and observes the register file, and `bsr_we` loads the bank-select register. No status flags exist.

Top module: `dskip_exec`

## Requirements
- R1: Only an instruction word whose bits [15:10] equal 001011 (skip when the result is zero) or 010011 (skip when the result is non-zero) is executed. Any other opcode presented at the decode phase changes nothing: the program counter, W and the register file stay unchanged.
- R2: The result is the operand byte minus one, modulo 256. An operand of 0x00 gives 0xFF.
- R3: Bit 9 of the instruction selects the destination. With 0, W takes the result and the file byte is left unchanged. With 1, the result is written back to the file byte and W is left unchanged.
- R4: With bit 8 equal to 0, the file address f (bits [7:0]) below ACCESS_SPLIT (0x60) selects bank 0. An address at or above it selects the top bank (all ones). The register-file index is {bank, f}.
- R5: With bit 8 equal to 1, the bank is the value of the bank-select register, which `bsr_we` loads from `bsr_din` and `bsr_out` shows.
- R6: Opcode 001011 skips when the result is zero. Opcode 010011 skips when the result is non-zero, and 0xFF from a wrapped decrement counts as non-zero.
- R7: A taken skip inserts one four-clock no-op cycle, or two when `next_two_word` was high when the instruction was taken. `busy` is high exactly during those cycles, and an instruction offered while `busy` is high is ignored.
- R8: `pc_out` (reset 0) rises by 2 at the end of every executed instruction cycle and every no-op cycle. A skip therefore costs 4 or 6 in total, and a non-skip costs 2.
- R9: An instruction is taken at the clock edge that ends the decode phase. Its result in W, in the file and in `pc_out` is visible after the third edge that follows.
- R10: `flush` is high for exactly one clock, right after the write edge of an instruction that skips, and low otherwise.
- R11: After reset, `phase` is 0, `pc_out`, `w_out` and `bsr_out` are 0, and `busy` and `flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word offered this clock |
| instr | input | 16 | Fetched instruction word |
| next_two_word | input | 1 | The instruction after this one is two words long |
| bsr_we | input | 1 | Load the bank-select register |
| bsr_din | input | BANK_W | Bank-select load value |
| ext_we | input | 1 | Side-port write to the register file |
| ext_addr | input | BANK_W+8 | Side-port register-file index |
| ext_din | input | 8 | Side-port write data |
| ext_dout | output | 8 | Register-file byte at ext_addr |
| phase | output | 2 | Current phase: 0 decode, 1 read, 2 compute, 3 write |
| busy | output | 1 | No-op cycles pending; new instructions refused |
| flush | output | 1 | Discard the already fetched instruction |
| pc_out | output | PC_W | Program counter in bytes |
| w_out | output | 8 | Working register |
| bsr_out | output | BANK_W | Bank-select register |

## Verification
An instruction is presented in a clock whose `phase` reads 0. The three clocks that follow must show the old program counter, no flush and no busy. W, the file byte, `pc_out`, `flush` and `busy` all change after the third edge. Each no-op cycle then spans four more clocks, and its program-counter step lands on its last edge. The bench steps its model on those same edges and compares the outputs at every falling edge across the whole window. Any result that arrives a clock early or late is therefore reported.

// File: rtl/dskip_pkg.sv
package dskip_pkg;

  localparam int DATA_W  = 8;
  localparam int FADDR_W = 8;
  localparam int INSTR_W = 16;

  localparam logic [5:0] OPC_SKIP_ZERO    = 6'b001011;
  localparam logic [5:0] OPC_SKIP_NONZERO = 6'b010011;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  typedef struct packed {
    logic               legal;
    logic               skip_nz;
    logic               to_file;
    logic               banked;
    logic [FADDR_W-1:0] faddr;
  } dec_t;

  // operand minus one, wrapping at the byte boundary
  function automatic logic [DATA_W-1:0] dec_byte(input logic [DATA_W-1:0] v);
    return v - {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  // skip polarity: zero-test variant or non-zero-test variant
  function automatic logic skip_taken(input logic nz_variant,
                                      input logic [DATA_W-1:0] r);
    return nz_variant ? (r != '0) : (r == '0);
  endfunction

endpackage

// File: rtl/dskip_decode.sv
module dskip_decode
  import dskip_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [5:0] opc;
  assign opc = instr[15:10];

  always_comb begin
    dec.legal   = (opc == OPC_SKIP_ZERO) || (opc == OPC_SKIP_NONZERO);
    dec.skip_nz = (opc == OPC_SKIP_NONZERO);
    dec.to_file = instr[9];
    dec.banked  = instr[8];
    dec.faddr   = instr[7:0];
  end
endmodule

// File: rtl/dskip_bank.sv
module dskip_bank
  import dskip_pkg::*;
#(
  parameter int               BANK_W       = 2,
  parameter logic [FADDR_W-1:0] ACCESS_SPLIT = 8'h60
) (
  input  logic                      banked,
  input  logic [FADDR_W-1:0]        faddr,
  input  logic [BANK_W-1:0]         bsr,
  output logic [BANK_W+FADDR_W-1:0] addr
);
  localparam logic [BANK_W-1:0] LOW_BANK = '0;
  localparam logic [BANK_W-1:0] SFR_BANK = '1;

  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    if (banked)                    bank_sel = bsr;
    else if (faddr < ACCESS_SPLIT) bank_sel = LOW_BANK;
    else                           bank_sel = SFR_BANK;
  end

  assign addr = {bank_sel, faddr};
endmodule

// File: rtl/dskip_regfile.sv
module dskip_regfile
  import dskip_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                      clk,
  input  logic                      core_we,
  input  logic [BANK_W+FADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0]         core_din,
  input  logic [BANK_W+FADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      ext_we,
  input  logic [BANK_W+FADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0]         ext_din,
  output logic [DATA_W-1:0]         ext_dout
);
  localparam int AW    = BANK_W + FADDR_W;
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // the core write port wins over the side port
  always_ff @(posedge clk) begin
    if (core_we)     mem[core_addr] <= core_din;
    else if (ext_we) mem[ext_addr]  <= ext_din;
  end

  assign rd_data  = mem[rd_addr];
  assign ext_dout = mem[ext_addr];
endmodule

// File: rtl/dskip_seq.sv
module dskip_seq
  import dskip_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_write,
  input  logic            skip,
  input  logic            two_word,
  output phase_e          phase,
  output logic            busy,
  output logic            nop_done,
  output logic [PC_W-1:0] pc
);
  localparam int NOP_W = 2;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);

  phase_e           ph_q;
  logic [NOP_W-1:0] nop_cnt;

  assign phase    = ph_q;
  assign busy     = (nop_cnt != '0);
  assign nop_done = (ph_q == PH_WRITE) && busy && !exec_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_DECODE;
      nop_cnt <= '0;
      pc      <= '0;
    end else begin
      ph_q <= phase_e'(ph_q + 2'd1);
      if (ph_q == PH_WRITE) begin
        if (exec_write && skip) nop_cnt <= two_word ? NOP_W'(2) : NOP_W'(1);
        else if (busy)          nop_cnt <= nop_cnt - NOP_W'(1);
        if (exec_write || nop_done) pc <= pc + PC_STEP;
      end
    end
  end
endmodule

// File: rtl/dskip_exec.sv
module dskip_exec
  import dskip_pkg::*;
#(
  parameter int                 BANK_W       = 2,
  parameter logic [FADDR_W-1:0] ACCESS_SPLIT = 8'h60,
  parameter int                 PC_W         = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue,
  input  logic [INSTR_W-1:0]        instr,
  input  logic                      next_two_word,
  input  logic                      bsr_we,
  input  logic [BANK_W-1:0]         bsr_din,
  input  logic                      ext_we,
  input  logic [BANK_W+FADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0]         ext_din,
  output logic [DATA_W-1:0]         ext_dout,
  output logic [1:0]                phase,
  output logic                      busy,
  output logic                      flush,
  output logic [PC_W-1:0]           pc_out,
  output logic [DATA_W-1:0]         w_out,
  output logic [BANK_W-1:0]         bsr_out
);
  localparam int RF_AW = BANK_W + FADDR_W;

  dec_t               dec_in;
  phase_e             ph;
  logic               act, two_l, skip_l, flush_q;
  logic               ir_nz, ir_file, ir_banked;
  logic [FADDR_W-1:0] ir_f;
  logic [DATA_W-1:0]  opnd, result, w_q, rd_data;
  logic [BANK_W-1:0]  bsr_q;
  logic [RF_AW-1:0]   op_addr;

  // named internal events, watched by the checker
  logic accept, exec_write, w_we, rf_we, nop_done;

  dskip_decode u_dec (.instr(instr), .dec(dec_in));

  dskip_bank #(.BANK_W(BANK_W), .ACCESS_SPLIT(ACCESS_SPLIT)) u_bank (
    .banked(ir_banked), .faddr(ir_f), .bsr(bsr_q), .addr(op_addr)
  );

  dskip_regfile #(.BANK_W(BANK_W)) u_rf (
    .clk(clk), .core_we(rf_we), .core_addr(op_addr), .core_din(result),
    .rd_addr(op_addr), .rd_data(rd_data),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_din(ext_din), .ext_dout(ext_dout)
  );

  dskip_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .exec_write(exec_write), .skip(skip_l),
    .two_word(two_l), .phase(ph), .busy(busy), .nop_done(nop_done), .pc(pc_out)
  );

  assign accept     = issue && (ph == PH_DECODE) && !busy && dec_in.legal;
  assign exec_write = act && (ph == PH_WRITE);
  assign w_we       = exec_write && !ir_file;
  assign rf_we      = exec_write && ir_file;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      two_l     <= 1'b0;
      ir_nz     <= 1'b0;
      ir_file   <= 1'b0;
      ir_banked <= 1'b0;
      ir_f      <= '0;
      opnd      <= '0;
      result    <= '0;
      skip_l    <= 1'b0;
      w_q       <= '0;
      flush_q   <= 1'b0;
      bsr_q     <= '0;
    end else begin
      if (accept) begin
        act       <= 1'b1;
        two_l     <= next_two_word;
        ir_nz     <= dec_in.skip_nz;
        ir_file   <= dec_in.to_file;
        ir_banked <= dec_in.banked;
        ir_f      <= dec_in.faddr;
      end else if (exec_write) begin
        act <= 1'b0;
      end
      if (act && ph == PH_READ) opnd <= rd_data;
      if (act && ph == PH_PROC) begin
        result <= dec_byte(opnd);
        skip_l <= skip_taken(ir_nz, dec_byte(opnd));
      end
      if (w_we)   w_q   <= result;
      if (bsr_we) bsr_q <= bsr_din;
      flush_q <= exec_write && skip_l;
    end
  end

  assign phase   = ph;
  assign flush   = flush_q;
  assign w_out   = w_q;
  assign bsr_out = bsr_q;
endmodule

// File: rtl/dskip_exec_chk.sv
module dskip_exec_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      phase,
  input logic            busy,
  input logic            flush,
  input logic [PC_W-1:0] pc_out,
  input logic [7:0]      w_out,
  input logic            accept,
  input logic            exec_write,
  input logic            nop_done,
  input logic            w_we
);
  // R9: the write phase of an instruction comes three edges after it was taken
  a_r9_write_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    exec_write |-> $past(accept, 3));

  // R9: the four phases run as a ring
  a_r9_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |=> (phase == 2'd0));

  // R8: two-byte step on every executed or no-op cycle
  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_write || nop_done) |=> (pc_out == $past(pc_out) + PC_W'(2)));

  // R8: no other change of the program counter
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_write || nop_done) |=> $stable(pc_out));

  // R10: the flush request lasts one clock
  a_r10_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R7: a flush always opens a no-op window
  a_r7_flush_busy: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> busy);

  // R7: nothing is taken while no-op cycles are pending
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 2'd1) |-> !$past(accept));

  // R3: W moves only on its own write
  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !w_we |=> $stable(w_out));
endmodule

bind dskip_exec dskip_exec_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .busy(busy), .flush(flush),
  .pc_out(pc_out), .w_out(w_out), .accept(accept), .exec_write(exec_write),
  .nop_done(nop_done), .w_we(w_we)
);

// File: tb/dskip_exec_bench.sv
module dskip_exec_bench;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic        next_two_word = 1'b0;
  logic        bsr_we = 1'b0;
  logic [BW-1:0] bsr_din = '0;
  logic        ext_we = 1'b0;
  logic [BW+7:0] ext_addr = '0;
  logic [7:0]  ext_din = '0;
  logic [7:0]  ext_dout;
  logic [1:0]  phase;
  logic        busy, flush;
  logic [15:0] pc_out;
  logic [7:0]  w_out;
  logic [BW-1:0] bsr_out;

  always #10 clk = ~clk;

  dskip_exec #(.BANK_W(BW)) u_dskip_exec (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .next_two_word(next_two_word), .bsr_we(bsr_we), .bsr_din(bsr_din),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_din(ext_din), .ext_dout(ext_dout),
    .phase(phase), .busy(busy), .flush(flush), .pc_out(pc_out),
    .w_out(w_out), .bsr_out(bsr_out)
  );

  int n_chk = 0, n_fail = 0;
  int mdl_mem [NB*256];
  int mdl_w = 0, mdl_pc = 0, mdl_bsr = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      report();
    end
  end

  task automatic poke(int addr, int v);
    ext_we = 1'b1; ext_addr = addr[BW+7:0]; ext_din = v[7:0];
    @(negedge clk);
    ext_we = 1'b0;
    mdl_mem[addr] = v;
  endtask

  task automatic peek(int addr, output int v);
    ext_addr = addr[BW+7:0];
    #1;
    v = int'(ext_dout);
  endtask

  task automatic set_bsr(int v);
    bsr_we = 1'b1; bsr_din = v[BW-1:0];
    @(negedge clk);
    bsr_we = 1'b0;
    mdl_bsr = v;
  endtask

  function automatic int index_of(bit a, int f);
    if (a) return mdl_bsr * 256 + f;
    return (f >= 96) ? (NB - 1) * 256 + f : f;
  endfunction

  // run one instruction; intrude offers a second instruction in the first no-op cycle
  task automatic run(string req, logic [5:0] opc, bit d, bit a, int f, bit tw, bit intrude);
    int idx, oldv, res, nops, got, pc0;
    bit legal, nz, skip;
    legal = (opc == 6'b001011) || (opc == 6'b010011);
    nz    = (opc == 6'b010011);
    idx   = index_of(a, f);
    oldv  = mdl_mem[idx];
    res   = (oldv == 0) ? 255 : oldv - 1;
    skip  = legal && (nz ? (res != 0) : (res == 0));
    nops  = skip ? (tw ? 2 : 1) : 0;
    while (phase !== 2'd0) @(negedge clk);
    issue = 1'b1; instr = {opc, d, a, f[7:0]}; next_two_word = tw;
    pc0 = mdl_pc;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      issue = 1'b0;
      chk("R9", "pc before write", int'(pc_out), pc0);
      chk("R10", "flush before write", int'(flush), 0);
      chk("R7", "busy before write", int'(busy), 0);
    end
    @(negedge clk);
    if (legal) begin
      mdl_pc += 2;
      if (d) mdl_mem[idx] = res; else mdl_w = res;
    end
    chk({req, "/R8"}, "pc after write", int'(pc_out), mdl_pc);
    chk({req, "/R3"}, "W", int'(w_out), mdl_w);
    peek(idx, got);
    chk({req, "/R2"}, "file byte", got, mdl_mem[idx]);
    chk({req, "/R10"}, "flush", int'(flush), int'(skip));
    chk({req, "/R7"}, "busy", int'(busy), int'(nops > 0));
    if (intrude) begin
      issue = 1'b1; instr = {6'b010011, 1'b0, 1'b0, 8'h10}; next_two_word = 1'b0;
    end
    for (int j = 0; j < nops; j++) begin
      for (int c = 1; c <= 4; c++) begin
        @(negedge clk);
        issue = 1'b0;
        if (c == 4) mdl_pc += 2;
        chk("R8", "pc in no-op", int'(pc_out), mdl_pc);
        chk("R7", "busy in no-op", int'(busy), (c < 4 || j < nops - 1) ? 1 : 0);
        chk("R10", "flush in no-op", int'(flush), 0);
        chk("R7", "W in no-op", int'(w_out), mdl_w);
      end
    end
  endtask

  initial begin
    int v;
    for (int i = 0; i < NB * 256; i++) mdl_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk("R11", "pc", int'(pc_out), 0);
    chk("R11", "W", int'(w_out), 0);
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "flush", int'(flush), 0);
    chk("R11", "phase", int'(phase), 0);
    chk("R11", "bank select", int'(bsr_out), 0);
    rst_n = 1'b1;

    poke(16'h010, 5); run("R6", 6'b001011, 1, 0, 8'h10, 0, 0);   // 5 -> 4, no skip
    poke(16'h011, 1); run("R6", 6'b001011, 1, 0, 8'h11, 0, 0);   // 1 -> 0, skip one
    poke(16'h012, 1); run("R7", 6'b001011, 1, 0, 8'h12, 1, 0);   // skip two-word
    poke(16'h013, 0); run("R2", 6'b010011, 1, 0, 8'h13, 0, 0);   // wrap to 0xFF, skip
    poke(16'h014, 1); run("R6", 6'b010011, 1, 0, 8'h14, 0, 0);   // 0 with nz: no skip
    poke(16'h015, 9); run("R3", 6'b001011, 0, 0, 8'h15, 0, 0);   // to W, file kept
    peek(16'h015, v); chk("R3", "file kept on W dest", v, 9);

    poke(16'h080, 3); poke(16'h380, 7);
    run("R4", 6'b010011, 1, 0, 8'h80, 0, 0);                      // top bank
    peek(16'h080, v); chk("R4", "bank 0 untouched", v, 3);
    peek(16'h380, v); chk("R4", "top bank result", v, 6);
    poke(16'h05F, 2);
    run("R4", 6'b001011, 1, 0, 8'h5F, 0, 0);                      // just below split
    peek(16'h35F, v); chk("R4", "top bank below split untouched", v, 0);

    set_bsr(2);
    chk("R5", "bank select load", int'(bsr_out), 2);
    poke(16'h210, 2);
    run("R5", 6'b001011, 1, 1, 8'h10, 0, 0);
    peek(16'h210, v); chk("R5", "banked result", v, 1);
    peek(16'h010, v); chk("R5", "bank 0 untouched", v, 4);

    run("R1", 6'b001010, 0, 0, 8'h15, 0, 0);                      // not a legal opcode
    run("R1", 6'b110011, 1, 0, 8'h10, 0, 0);
    peek(16'h010, v); chk("R1", "file untouched by other opcode", v, 4);

    poke(16'h020, 1); run("R7", 6'b001011, 1, 0, 8'h20, 0, 1);   // offer during busy
    chk("R7", "W after refused issue", int'(w_out), mdl_w);
    peek(16'h010, v); chk("R7", "file after refused issue", v, 4);

    repeat (2) @(negedge clk);
    done = 1;
    report();
  end
endmodule